// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block holds a set of wide event counters for a receive datapath. Each counter has its own one-cycle increment strobe, and software reads them through a plain 32-bit register port. Every counter appears as two consecutive word addresses. The low 32 bits are at the even address and the upper bits are at the odd address above it. Reads have no side effects, and a counter that passes its maximum value wraps to zero without any flag.

A configuration word gives software two controls. Bit 0 is a self-clearing request that zeroes every live counter. Bit 2 is a snapshot control. When it rises, all live counters are copied into shadow registers at one clock edge. While it stays high, counter reads return those frozen copies and the live counters keep counting underneath. The bank also has a scratch register, a revision word and three read-only words that hold a 12-character ASCII name. A build parameter can remove the counters entirely, and every counter read then returns zero.

Top module: `stat_bank`

## Requirements
- R1: A strobe on `cnt_inc[i]` in a cycle adds one to counter i at that clock edge. The counter's low word reads at address 2·i and its upper bits at address 2·i+1, zero-extended to 32 bits.
- R2: A counter that is CNT_W bits wide wraps from its all-ones value to zero on the next increment, with no saturation.
- R3: Reading a counter never changes its value, live or shadow.
- R4: Writing the configuration word (address 0x45) with bit 0 set zeroes every live counter at that edge, even when an increment strobe arrives in the same cycle. Bit 0 always reads back as 0.
- R5: A 0→1 change of configuration bit 2 copies every live counter into its shadow at that edge. The copy holds each count as it stood before that edge's increments or clear. While bit 2 reads 1, counter reads return the shadow values and the live counters keep counting. Once bit 2 is written back to 0, reads show the live counts again.
- R6: Writing bit 2 as 1 while it is already 1 does not take a new snapshot.
- R7: When STATS_EN is 0, every counter address reads as zero.
- R8: The scratch register at address 0x41 resets to 0x09 and reads back the last value written to it.
- R9: Address 0x40 returns REV_ID, and addresses 0x42, 0x43 and 0x44 return the three name words. Writes to these addresses are ignored.
- R10: Every address that is neither a counter word nor 0x40–0x45 reads as zero. The configuration word reads bit 2 as the snapshot state and all other bits as zero.
- R11: Read data and `rd_vld` appear exactly one cycle after `rd_en`. Both are zero out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_inc | input | NUM_CNT | Per-counter increment strobes |
| rd_en | input | 1 | Read request for `addr` |
| wr_en | input | 1 | Write request for `addr` |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_vld | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
The bench drives the same stimulus into three builds with NUM_CNT = 4:
- The first uses the default 64-bit counters and checks the word layout and the snapshot behaviour.
- The second narrows CNT_W to 8, so a few hundred strobes carry a counter through its wrap and into the shadow path after wrapping.
- The third sets STATS_EN to 0. Every counter address must then read zero while the scratch, name and configuration words still behave normally.

A behavioural model compares the read data of all three builds against its own counts on every clock.

// File: rtl/stat_bank_pkg.sv
// Package: shared register offsets, config bit positions and read-select type
// for the statistics counter bank. Assumes word addressing, 32-bit data.
package stat_bank_pkg;
    localparam int WORD_W      = 32;
    localparam int VAL_W       = 64;
    localparam int OFF_REV     = 'h40;
    localparam int OFF_SCR     = 'h41;
    localparam int OFF_ID0     = 'h42;
    localparam int OFF_ID1     = 'h43;
    localparam int OFF_ID2     = 'h44;
    localparam int OFF_CFG     = 'h45;
    localparam int CFG_CLR_BIT = 0;
    localparam int CFG_SHD_BIT = 2;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CNT, SEL_REV, SEL_SCR,
        SEL_ID0, SEL_ID1, SEL_ID2, SEL_CFG
    } reg_sel_e;
endpackage

// File: rtl/stat_cnt_lane.sv
// One live counter with its shadow copy. The live counter clears on clr
// (priority over inc) and wraps silently. The shadow loads the live value on
// cap. Output is the selected value zero-extended to 64 bits.
// Assumes CNT_W <= 64.
module stat_cnt_lane #(
    parameter int CNT_W = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        inc,
    input  logic        cap,
    input  logic        use_shadow,
    output logic [63:0] val
);
    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] shadow_q;

    // Live count: clear wins over increment, wrap on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)   live_q <= '0;
        else if (clr) live_q <= '0;
        else if (inc) live_q <= live_q + 1'b1;
    end

    // Shadow copy: loaded only on a capture pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)   shadow_q <= '0;
        else if (cap) shadow_q <= live_q;
    end

    // Present either the frozen or the live value, widened to 64 bits.
    always_comb begin
        val = 64'(use_shadow ? shadow_q : live_q);
    end
endmodule

// File: rtl/stat_cfg_regs.sv
// Configuration and scratch storage. Turns a configuration write into a
// one-cycle clear pulse and a rising-edge capture pulse, and keeps the
// snapshot state bit. Assumes wr_cfg and wr_scr are already address-qualified.
module stat_cfg_regs
    import stat_bank_pkg::*;
#(
    parameter logic [31:0] SCRATCH_RST = 32'h0000_0009
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cfg,
    input  logic        wr_scr,
    input  logic [31:0] wdata,
    output logic        clr_pulse,
    output logic        cap_pulse,
    output logic        shadow_on,
    output logic [31:0] scratch
);
    // Clear acts in the same edge as the write; nothing is stored for it.
    always_comb begin
        clr_pulse = wr_cfg && wdata[CFG_CLR_BIT];
        cap_pulse = wr_cfg && wdata[CFG_SHD_BIT] && !shadow_on;
    end

    // Snapshot state follows the written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_on <= 1'b0;
        else if (wr_cfg) shadow_on <= wdata[CFG_SHD_BIT];
    end

    // Scratch word, software read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)      scratch <= SCRATCH_RST;
        else if (wr_scr) scratch <= wdata;
    end
endmodule

// File: rtl/stat_addr_dec.sv
// Address decoder: sorts a word address into a register class, and for counter
// words gives the counter index and the high/low half. Assumes 2*NUM_CNT <= 64
// and NUM_CNT is a power of two.
module stat_addr_dec
    import stat_bank_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int ADDR_W  = 8,
    localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);
    localparam logic [ADDR_W-1:0] CNT_SPAN = ADDR_W'(2 * NUM_CNT);

    // Classify the address.
    always_comb begin
        idx = addr[IDX_W:1];
        hi  = addr[0];
        if (addr < CNT_SPAN)                  sel = SEL_CNT;
        else if (addr == ADDR_W'(OFF_REV))    sel = SEL_REV;
        else if (addr == ADDR_W'(OFF_SCR))    sel = SEL_SCR;
        else if (addr == ADDR_W'(OFF_ID0))    sel = SEL_ID0;
        else if (addr == ADDR_W'(OFF_ID1))    sel = SEL_ID1;
        else if (addr == ADDR_W'(OFF_ID2))    sel = SEL_ID2;
        else if (addr == ADDR_W'(OFF_CFG))    sel = SEL_CFG;
        else                                  sel = SEL_NONE;
    end
endmodule

// File: rtl/stat_bank.sv
// Statistics counter bank top. NUM_CNT counters of CNT_W bits, each read as
// two 32-bit words. A snapshot bit freezes all readable values at once.
// Registered read port: data and valid one cycle after rd_en.
// Assumes rd_en and wr_en are not used together for dependent results:
// a read in a write cycle returns the pre-write state.
module stat_bank
    import stat_bank_pkg::*;
#(
    parameter int          NUM_CNT     = 8,
    parameter int          CNT_W       = 64,
    parameter int          ADDR_W      = 8,
    parameter bit          STATS_EN    = 1'b1,
    parameter logic [31:0] REV_ID      = 32'h0001_0002,
    parameter logic [31:0] SCRATCH_RST = 32'h0000_0009,
    parameter logic [31:0] NAME_W0     = "rxSt",
    parameter logic [31:0] NAME_W1     = "atsB",
    parameter logic [31:0] NAME_W2     = "ank0",
    localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] cnt_inc,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               rd_vld
);
    reg_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    logic              clr_pulse, cap_pulse, shadow_on;
    logic [31:0]       scratch;
    logic [63:0]       cnt_val [NUM_CNT];
    logic [63:0]       cur_val;
    logic [31:0]       rd_word;

    stat_addr_dec #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .sel(sel), .idx(idx), .hi(hi)
    );

    stat_cfg_regs #(.SCRATCH_RST(SCRATCH_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_cfg(wr_en && sel == SEL_CFG),
        .wr_scr(wr_en && sel == SEL_SCR),
        .wdata(wdata),
        .clr_pulse(clr_pulse), .cap_pulse(cap_pulse),
        .shadow_on(shadow_on), .scratch(scratch)
    );

    // Counter lanes exist only when the statistics option is built in.
    generate
        if (STATS_EN) begin : g_cnt
            for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
                stat_cnt_lane #(.CNT_W(CNT_W)) u_lane (
                    .clk(clk), .rst_n(rst_n),
                    .clr(clr_pulse), .inc(cnt_inc[g]), .cap(cap_pulse),
                    .use_shadow(shadow_on), .val(cnt_val[g])
                );
            end
        end else begin : g_nocnt
            for (genvar g = 0; g < NUM_CNT; g++) begin : g_zero
                assign cnt_val[g] = '0;
            end
        end
    endgenerate

    // Pick the word addressed by the current request.
    always_comb begin
        cur_val = cnt_val[idx];
        case (sel)
            SEL_CNT: rd_word = hi ? cur_val[63:32] : cur_val[31:0];
            SEL_REV: rd_word = REV_ID;
            SEL_SCR: rd_word = scratch;
            SEL_ID0: rd_word = NAME_W0;
            SEL_ID1: rd_word = NAME_W1;
            SEL_ID2: rd_word = NAME_W2;
            SEL_CFG: rd_word = {29'b0, shadow_on, 2'b00};
            default: rd_word = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rd_vld <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) rdata <= rd_word;
        end
    end
endmodule

// File: rtl/stat_bank_chk.sv
// Checker for stat_bank: read-port timing and fixed-value read rules.
module stat_bank_chk
    import stat_bank_pkg::*;
#(
    parameter int          NUM_CNT  = 8,
    parameter int          ADDR_W   = 8,
    parameter bit          STATS_EN = 1'b1,
    parameter logic [31:0] REV_ID   = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       rdata,
    input  logic              rd_vld
);
    logic rsv_addr, cnt_addr;
    always_comb begin
        cnt_addr = int'(addr) < 2 * NUM_CNT;
        rsv_addr = !cnt_addr && (int'(addr) < OFF_REV || int'(addr) > OFF_CFG);
    end

    assert_vld_after_rd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_vld);
    assert_no_vld_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_vld);
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rsv_addr) |=> rdata == 32'h0);
    assert_rev_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) == OFF_REV) |=> rdata == REV_ID);
    assert_clr_bit_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) == OFF_CFG) |=> rdata[CFG_CLR_BIT] == 1'b0);
    assert_off_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!STATS_EN && rd_en && cnt_addr) |=> rdata == 32'h0);
endmodule

bind stat_bank stat_bank_chk #(
    .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .STATS_EN(STATS_EN), .REV_ID(REV_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
    .rdata(rdata), .rd_vld(rd_vld)
);

// File: tb/stat_bank_test.sv
// Bench: three builds (64-bit, 8-bit, counters off) share one stimulus; a
// behavioural model predicts every read and is compared on every clock.
module stat_bank_test;
    localparam int NC = 4;
    localparam logic [31:0] REV = 32'h0001_0002;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] cnt_inc = '0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata [3];
    logic          rd_vld [3];

    always #10 clk = ~clk;

    stat_bank #(.NUM_CNT(NC)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_inc(cnt_inc), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata[0]), .rd_vld(rd_vld[0]));
    stat_bank #(.NUM_CNT(NC), .CNT_W(8)) uut_wrap (
        .clk(clk), .rst_n(rst_n), .cnt_inc(cnt_inc), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata[1]), .rd_vld(rd_vld[1]));
    stat_bank #(.NUM_CNT(NC), .STATS_EN(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .cnt_inc(cnt_inc), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata[2]), .rd_vld(rd_vld[2]));

    // ---------------- reference model ----------------
    longint unsigned m_live [3][NC];
    longint unsigned m_sh   [3][NC];
    bit              m_sh_on;
    logic [31:0]     m_scr;
    bit              exp_vld;
    logic [31:0]     exp_dat [3];
    string           exp_tag [3];
    int              n_chk = 0, n_err = 0;
    bit              done = 1'b0;

    function automatic longint unsigned wmask(int k);
        return (k == 1) ? 64'hFF : 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    function automatic logic [31:0] mread(int k, logic [7:0] a);
        longint unsigned v;
        if (a < 2 * NC) begin
            if (k == 2) return 32'h0;
            v = m_sh_on ? m_sh[k][a >> 1] : m_live[k][a >> 1];
            return a[0] ? v[63:32] : v[31:0];
        end
        case (a)
            8'h40: return REV;
            8'h41: return m_scr;
            8'h42: return "rxSt";
            8'h43: return "atsB";
            8'h44: return "ank0";
            8'h45: return {29'b0, m_sh_on, 2'b00};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string mtag(int k, logic [7:0] a);
        if (a < 2 * NC) return (k == 2) ? "R7" : m_sh_on ? "R5" : (k == 1) ? "R2" : "R1";
        if (a == 8'h41) return "R8";
        if (a == 8'h45) return "R4";
        if (a >= 8'h40 && a <= 8'h44) return "R9";
        return "R10";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < NC; i++) begin m_live[k][i] = 0; m_sh[k][i] = 0; end
            m_sh_on = 1'b0; m_scr = 32'h9; exp_vld = 1'b0;
        end else begin
            exp_vld = rd_en;
            if (rd_en)
                for (int k = 0; k < 3; k++) begin
                    exp_dat[k] = mread(k, addr); exp_tag[k] = mtag(k, addr);
                end
            if (wr_en && addr == 8'h45) begin
                if (wdata[2] && !m_sh_on)
                    for (int k = 0; k < 3; k++)
                        for (int i = 0; i < NC; i++) m_sh[k][i] = m_live[k][i];
                m_sh_on = wdata[2];
            end
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < NC; i++)
                    if (wr_en && addr == 8'h45 && wdata[0]) m_live[k][i] = 0;
                    else if (cnt_inc[i]) m_live[k][i] = (m_live[k][i] + 1) & wmask(k);
            if (wr_en && addr == 8'h41) m_scr = wdata;
        end
    end

    // Compare every build on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done)
            for (int k = 0; k < 3; k++) begin
                n_chk++;
                if (rd_vld[k] !== exp_vld) begin
                    n_err++;
                    $display("FAIL R11 build%0d rd_vld actual=%b expected=%b", k, rd_vld[k], exp_vld);
                end
                if (exp_vld) begin
                    n_chk++;
                    if (rdata[k] !== exp_dat[k]) begin
                        n_err++;
                        $display("FAIL %s build%0d rdata actual=%h expected=%h",
                                 exp_tag[k], k, rdata[k], exp_dat[k]);
                    end
                end
            end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic r, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [NC-1:0] i);
        rd_en = r; wr_en = w; addr = a; wdata = d; cnt_inc = i;
        @(negedge clk);
    endtask

    task automatic sweep(input bit busy);
        for (int a = 0; a < 8'h48; a++) cyc(1, 0, 8'(a), 0, busy ? NC'($urandom) : '0);
        cyc(1, 0, 8'hFF, 0, '0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of the read port
        for (int k = 0; k < 3; k++) begin
            n_chk++;
            if (rdata[k] !== 32'h0 || rd_vld[k] !== 1'b0) begin
                n_err++;
                $display("FAIL R11 build%0d reset actual=%h/%b expected=0/0", k, rdata[k], rd_vld[k]);
            end
        end
        // R8, R10: reset values, quiet sweep
        sweep(0);
        // R1, R3: random strobes with repeated reads
        for (int n = 0; n < 3; n++) sweep(1);
        // R8, R9: scratch write, writes to read-only words ignored
        cyc(0, 1, 8'h41, 32'hA5A5_1234, '0);
        cyc(0, 1, 8'h40, 32'hFFFF_FFFF, '0);
        cyc(0, 1, 8'h42, 32'h0, '0);
        cyc(0, 1, 8'h44, 32'h1, '0);
        sweep(0);
        // R2: drive counter 0 through the 8-bit wrap, reading as it goes
        for (int n = 0; n < 300; n++) cyc(1, 0, 8'(n % 2), 0, 4'b0001);
        sweep(0);
        // R5: snapshot while strobes keep arriving
        cyc(0, 1, 8'h45, 32'h4, 4'b1111);
        sweep(1);
        // R6: second write of bit 2 must not re-capture
        cyc(0, 1, 8'h45, 32'h4, 4'b1010);
        sweep(1);
        cyc(0, 1, 8'h45, 32'h0, '0);
        sweep(1);
        // R4: clear colliding with increments on every counter
        cyc(0, 1, 8'h45, 32'h1, 4'b1111);
        sweep(0);
        // R4 + R5: clear and snapshot together: shadow keeps pre-clear counts
        sweep(1);
        cyc(0, 1, 8'h45, 32'h5, 4'b1111);
        sweep(1);
        cyc(0, 1, 8'h45, 32'h0, '0);
        sweep(0);
        cyc(0, 0, 8'h0, 0, '0);
        cyc(0, 0, 8'h0, 0, '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule